// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a two-channel pulse-width modulator. A 16-bit counter walks through a programmable period and gives the rest of the modulator its reference. The neighbouring logic (compare and output-action stages) only needs the counter value, the moment the counter lands on zero, the moment it lands on the period value, and the direction it is moving in. Software configures the block through two write strobes. One strobe loads a control word that picks the counting pattern, the period-load policy and two cascaded clock dividers. The other strobe loads the period word.

The counter advances once per prescaled tick. The prescale is the product of two stages with unlike encodings. One stage is a binary power of two. The other divides by one or by an even number. A period write goes either straight to the active period or into a shadow copy. The shadow copy is promoted only at a zero crossing, so a running waveform never sees a half-finished period change.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0, the direction flag shows up-counting (1), both event pulses are low, the control word is all zero (up mode, shadow loading, prescale 1) and both the active and shadow periods are 0.
- R2: Mode field (control bits 1:0) = 00 counts up. On each tick the counter goes to 0 if it is at or above the active period, and otherwise it increments. The zero pulse therefore repeats every (period+1)·prescale clocks.
- R3: Mode 01 counts down. On a tick the counter reloads the active period if it is 0, and otherwise it decrements. The direction flag reads 0.
- R4: Mode 10 counts up and down. It reverses to down-counting on a tick taken at or above the period, and to up-counting on a tick taken at 0. The direction flag tracks the current direction.
- R5: Mode 11 freezes the counter and the direction flag and raises no event pulses.
- R6: Control bits 12:10 hold c, and that stage divides the clock by 2^c (c = 0..7).
- R7: Control bits 9:7 hold h, and that stage divides by 1 when h = 0 and by 2·h otherwise. The total prescale is the product of the two stages.
- R8: With control bit 3 = 0, a period write lands in the shadow copy. The shadow moves into the active period on a tick taken while the counter is 0, and that same tick already uses the new value.
- R9: With control bit 3 = 1, a period write updates the active period (and the shadow) in the next cycle.
- R10: The zero pulse and the period pulse are each one clock wide. They are high exactly in the first cycle in which the counter shows 0, or shows the period value, after a tick.
- R11: Every control write restarts the prescaler from zero, and no tick occurs in the cycle of the write.
- R12: While the enable input is low, the counter, the prescaler and the direction flag hold, and no pulses are raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable; gates the prescaler |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word: mode 1:0, load policy 3, stage-B 9:7, stage-A 12:10 |
| prd_we_i | input | 1 | Period word write strobe |
| prd_wdata_i | input | 16 | Period value |
| cnt_o | output | 16 | Counter value |
| zero_o | output | 1 | Pulse in the first cycle the counter shows 0 |
| prd_o | output | 1 | Pulse in the first cycle the counter shows the period |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |

## Verification
The hardest case to reach is the shadow promotion. A period write has to sit pending while the counter keeps running on the old value, and the new value must then take hold on the exact tick at which the counter is zero. The stimulus writes a shorter period in mid-count under several modes, including down mode, where zero comes just before a reload. A cycle-accurate behavioural model follows each write through to that tick. Long prescales are reached by measuring zero-pulse intervals at the largest product of both stages.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    localparam int unsigned CTL_W    = 16;
    localparam int unsigned CDIV_W   = 3;
    localparam int unsigned HDIV_W   = 3;

    // control word field positions, fixed by the software view
    localparam int unsigned MODE_LSB = 0;
    localparam int unsigned LOAD_BIT = 3;
    localparam int unsigned HDIV_LSB = 7;
    localparam int unsigned CDIV_LSB = 10;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic [CDIV_W-1:0] cdiv;
        logic [HDIV_W-1:0] hdiv;
        logic              imm;
        cnt_mode_e         mode;
    } ctl_t;

    // width of a counter able to hold the largest total prescale
    function automatic int unsigned pre_width(int unsigned cw, int unsigned hw);
        int unsigned max_a;
        int unsigned max_b;
        max_a = 1 << ((1 << cw) - 1);
        max_b = 2 * ((1 << hw) - 1);
        return $clog2(max_a * max_b + 1);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned CDIV_W = 3,
    parameter int unsigned HDIV_W = 3,
    parameter int unsigned PRE_W  = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              restart_i,
    input  logic [CDIV_W-1:0] cdiv_i,
    input  logic [HDIV_W-1:0] hdiv_i,
    output logic              tick_o,
    output logic [PRE_W-1:0]  pre_cnt_o,
    output logic [PRE_W-1:0]  div_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] stage_a;
    logic [PRE_W-1:0] stage_b;
    logic [PRE_W-1:0] div_total;
    logic             tick;

    // stage A: power of two; stage B: 1 or an even factor
    always_comb begin
        stage_a   = PRE_W'(1) << cdiv_i;
        stage_b   = (hdiv_i == '0) ? PRE_W'(1) : PRE_W'({hdiv_i, 1'b0});
        div_total = stage_a * stage_b;
        tick      = en_i && !restart_i && (s_q.cnt == div_total - PRE_W'(1));
    end

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (en_i) begin
            s_d.cnt = tick ? '0 : s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o    = tick;
    assign pre_cnt_o = s_q.cnt;
    assign div_o     = div_total;

endmodule

// File: rtl/pwm_period_regs.sv
module pwm_period_regs #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             imm_i,
    input  logic             tick_i,
    input  logic             cnt_zero_i,
    output logic [CNT_W-1:0] prd_eff_o
);

    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] shd;
    } prd_state_t;

    prd_state_t s_d, s_q;
    logic       promote;

    always_comb begin
        promote   = tick_i && !imm_i && cnt_zero_i;
        prd_eff_o = promote ? s_q.shd : s_q.act;
    end

    always_comb begin
        s_d     = s_q;
        s_d.act = prd_eff_o;
        if (we_i) begin
            s_d.shd = wdata_i;
            if (imm_i) begin
                s_d.act = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pwm_counter_core.sv
module pwm_counter_core
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  cnt_mode_e        mode_i,
    input  logic [CNT_W-1:0] prd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             zero_o,
    output logic             prd_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             zero;
        logic             pmatch;
    } core_state_t;

    core_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.zero   = 1'b0;
        s_d.pmatch = 1'b0;
        if (tick_i && mode_i != MODE_HOLD) begin
            unique case (mode_i)
                MODE_UP: begin
                    s_d.dir_up = 1'b1;
                    s_d.cnt    = (s_q.cnt >= prd_i) ? '0 : s_q.cnt + CNT_W'(1);
                end
                MODE_DOWN: begin
                    s_d.dir_up = 1'b0;
                    s_d.cnt    = (s_q.cnt == '0) ? prd_i : s_q.cnt - CNT_W'(1);
                end
                MODE_UPDN: begin
                    if (s_q.dir_up) begin
                        if (s_q.cnt >= prd_i) begin
                            s_d.dir_up = 1'b0;
                            s_d.cnt    = (s_q.cnt == '0) ? '0 : s_q.cnt - CNT_W'(1);
                        end else begin
                            s_d.cnt    = s_q.cnt + CNT_W'(1);
                        end
                    end else begin
                        if (s_q.cnt == '0) begin
                            s_d.dir_up = 1'b1;
                            s_d.cnt    = (prd_i == '0) ? '0 : CNT_W'(1);
                        end else begin
                            s_d.cnt    = s_q.cnt - CNT_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
            s_d.zero   = (s_d.cnt == '0);
            s_d.pmatch = (s_d.cnt == prd_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.dir_up <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o    = s_q.cnt;
    assign dir_up_o = s_q.dir_up;
    assign zero_o   = s_q.zero;
    assign prd_o    = s_q.pmatch;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic             prd_we_i,
    input  logic [CNT_W-1:0] prd_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             prd_o,
    output logic             dir_up_o
);

    localparam int unsigned PRE_W = pre_width(CDIV_W, HDIV_W);

    ctl_t             ctl_d, ctl_q;
    logic             tick;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_div;
    logic [CNT_W-1:0] prd_eff;
    logic [CNT_W-1:0] cnt;
    logic             unused_ctl_bits;

    assign unused_ctl_bits = ^{ctl_wdata_i[CTL_W-1:CDIV_LSB+CDIV_W],
                               ctl_wdata_i[HDIV_LSB-1:LOAD_BIT+1],
                               ctl_wdata_i[LOAD_BIT-1:MODE_LSB+2]};

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we_i) begin
            ctl_d.mode = cnt_mode_e'(ctl_wdata_i[MODE_LSB +: 2]);
            ctl_d.imm  = ctl_wdata_i[LOAD_BIT];
            ctl_d.hdiv = ctl_wdata_i[HDIV_LSB +: HDIV_W];
            ctl_d.cdiv = ctl_wdata_i[CDIV_LSB +: CDIV_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwm_prescaler #(
        .CDIV_W (CDIV_W),
        .HDIV_W (HDIV_W),
        .PRE_W  (PRE_W)
    ) i_prescaler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .restart_i (ctl_we_i),
        .cdiv_i    (ctl_q.cdiv),
        .hdiv_i    (ctl_q.hdiv),
        .tick_o    (tick),
        .pre_cnt_o (pre_cnt),
        .div_o     (pre_div)
    );

    pwm_period_regs #(
        .CNT_W (CNT_W)
    ) i_period (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (prd_we_i),
        .wdata_i    (prd_wdata_i),
        .imm_i      (ctl_q.imm),
        .tick_i     (tick),
        .cnt_zero_i (cnt == '0),
        .prd_eff_o  (prd_eff)
    );

    pwm_counter_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .mode_i   (ctl_q.mode),
        .prd_i    (prd_eff),
        .cnt_o    (cnt),
        .dir_up_o (dir_up_o),
        .zero_o   (zero_o),
        .prd_o    (prd_o)
    );

    assign cnt_o = cnt;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PRE_W = 11
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             ctl_we_i,
    input cnt_mode_e        mode_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             zero_i,
    input logic             prd_i,
    input logic [PRE_W-1:0] pre_cnt_i,
    input logic [PRE_W-1:0] div_i
);

    // R12: disabled block freezes and stays quiet
    p_hold_disabled_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(cnt_i) && !zero_i && !prd_i));

    // R5: frozen mode keeps the counter
    p_hold_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_HOLD && !ctl_we_i) |=> $stable(cnt_i));

    // R2: up mode moves by one step or wraps to zero
    p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_UP && !ctl_we_i) |=>
        (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1) || cnt_i == '0));

    // R10: zero pulse only while the counter shows zero
    p_zero_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_i |-> (cnt_i == '0));

    // R11: prescaler count stays below the programmed division
    p_pre_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_cnt_i < div_i);

endmodule

bind pwm_timebase pwm_timebase_chk #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
) i_pwm_timebase_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ctl_we_i  (ctl_we_i),
    .mode_i    (ctl_q.mode),
    .cnt_i     (cnt),
    .zero_i    (zero_o),
    .prd_i     (prd_o),
    .pre_cnt_i (pre_cnt),
    .div_i     (pre_div)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [15:0] ctl_wdata_i = '0;
    logic        prd_we_i = 1'b0;
    logic [15:0] prd_wdata_i = '0;
    logic [15:0] cnt_o;
    logic        zero_o;
    logic        prd_o;
    logic        dir_up_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string req = "R1";

    // behavioural reference state
    int m_ctl = 0, m_act = 0, m_shd = 0, m_pre = 0, m_cnt = 0;
    int m_dir = 1, m_z = 0, m_p = 0;

    always #2 clk_i = ~clk_i;

    pwm_timebase i_pwm_timebase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_wdata_i (ctl_wdata_i),
        .prd_we_i    (prd_we_i),
        .prd_wdata_i (prd_wdata_i),
        .cnt_o       (cnt_o),
        .zero_o      (zero_o),
        .prd_o       (prd_o),
        .dir_up_o    (dir_up_o)
    );

    function automatic int prescale(int ctl);
        int c = (ctl >> 10) & 7;
        int h = (ctl >> 7) & 7;
        return (1 << c) * ((h == 0) ? 1 : 2 * h);
    endfunction

    task automatic model_clock();
        int div = prescale(m_ctl);
        int mode = m_ctl & 3;
        bit tick = en_i && !ctl_we_i && (m_pre == div - 1);
        bit load = tick && ((m_ctl & 8) == 0) && (m_cnt == 0);
        int p = load ? m_shd : m_act;
        if (ctl_we_i) m_pre = 0;
        else if (en_i) m_pre = tick ? 0 : m_pre + 1;
        m_z = 0; m_p = 0;
        if (tick && mode != 3) begin
            if (mode == 0) begin
                m_dir = 1; m_cnt = (m_cnt >= p) ? 0 : m_cnt + 1;
            end else if (mode == 1) begin
                m_dir = 0; m_cnt = (m_cnt == 0) ? p : m_cnt - 1;
            end else if (m_dir == 1) begin
                if (m_cnt >= p) begin m_dir = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_dir = 1; m_cnt = (p == 0) ? 0 : 1; end
                else m_cnt = m_cnt - 1;
            end
            m_z = (m_cnt == 0);
            m_p = (m_cnt == p);
        end
        m_act = p;
        if (prd_we_i) begin
            m_shd = prd_wdata_i;
            if (m_ctl & 8) m_act = prd_wdata_i;
        end
        if (ctl_we_i) m_ctl = ctl_wdata_i;
    endtask

    task automatic compare();
        n_checks++;
        if (cnt_o !== 16'(m_cnt) || zero_o !== 1'(m_z) || prd_o !== 1'(m_p) || dir_up_o !== 1'(m_dir)) begin
            n_fail++;
            $display("FAIL %s: cnt/zero/prd/dir actual %0d/%0b/%0b/%0b expected %0d/%0d/%0d/%0d",
                     req, cnt_o, zero_o, prd_o, dir_up_o, m_cnt, m_z, m_p, m_dir);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        model_clock();
        @(negedge clk_i);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_ctl(int v);
        ctl_wdata_i = 16'(v); ctl_we_i = 1'b1;
        step();
        ctl_we_i = 1'b0;
    endtask

    task automatic wr_prd(int v);
        prd_wdata_i = 16'(v); prd_we_i = 1'b1;
        step();
        prd_we_i = 1'b0;
    endtask

    // R2 / R6 / R7: zero-pulse interval equals (period+1)*prescale
    task automatic measure(int ctl, int prd);
        int k = 0;
        int exp_n = (prd + 1) * prescale(ctl);
        wr_ctl(ctl);
        wr_prd(prd);
        do begin step(); k++; end while (!zero_o && k < 20000);
        k = 0;
        do begin step(); k++; end while (!zero_o && k < 20000);
        n_checks++;
        if (k != exp_n) begin
            n_fail++;
            $display("FAIL %s: zero interval actual %0d expected %0d", req, k, exp_n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        req = "R1";
        compare();
        rst_ni = 1'b1;
        @(negedge clk_i);
        compare();

        en_i = 1'b1;
        req = "R9";
        wr_ctl(16'h0008);
        wr_prd(9);
        run(30);

        req = "R2";
        measure(16'h0008, 9);
        req = "R6";
        measure(16'h0808, 5);
        measure(16'h1C08, 2);
        req = "R7";
        measure(16'h0188, 4);
        measure(16'h0508, 7);
        measure(16'h1F88, 2);
        measure(16'h0C88, 0);

        req = "R3";
        wr_ctl(16'h0409);
        wr_prd(6);
        run(50);

        req = "R4";
        wr_ctl(16'h000A);
        wr_prd(5);
        run(60);

        req = "R10";
        wr_ctl(16'h040A);
        wr_prd(3);
        run(40);

        req = "R5";
        wr_ctl(16'h000B);
        run(15);
        wr_prd(7);
        run(10);

        req = "R12";
        wr_ctl(16'h0008);
        run(5);
        en_i = 1'b0;
        run(20);
        en_i = 1'b1;
        run(10);

        req = "R8";
        wr_ctl(16'h0000);
        run(4);
        wr_prd(3);
        run(30);
        wr_ctl(16'h0001);
        run(2);
        wr_prd(12);
        run(40);
        wr_prd(2);
        prd_wdata_i = 16'd5; prd_we_i = 1'b1;
        ctl_wdata_i = 16'h0008; ctl_we_i = 1'b1;
        step();
        prd_we_i = 1'b0; ctl_we_i = 1'b0;
        run(30);

        req = "R9";
        wr_prd(12);
        run(10);
        wr_prd(4);
        run(30);

        req = "R11";
        wr_ctl(16'h0C08);
        for (int i = 0; i < 6; i++) begin
            run(5);
            wr_ctl(16'h0C08);
        end
        run(40);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule